// File: doc/BRIEF.md
# Multicore Debug Halt Coordinator

This block ties the debug halts of a small cluster of cores together. Each core
presents four halt-cause lines: a software write of its halt flag, an
actionpoint hit, a breakpoint and a self-halt. Software selects which cores take
part and which causes count. When a participating core raises a counted cause,
the coordinator drives a halt request to every participating core and holds it
until software releases those cores one by one or all together.

A second, independent core mask governs a shared 64-bit free-running counter. The
counter advances by one each cycle. It freezes in any cycle in which a core of
that mask is halted, meaning its halt request is asserted or any of its cause
lines is high. The counter can be read as two 32-bit words, and the high word is
captured when the low word is read.

Software reaches the block through a single-cycle command port that carries a code,
a parameter and a data word. A readback register holds the result of the latest
command. A halt controller works as a state machine with three states: `S_RUN`
(no request), `S_SEIZE` (first cycle of a halt, in which releases are ignored) and
`S_HELD` (request held). The transitions are *trigger* (RUN to SEIZE, target mask
loaded from the select mask), *settle* (SEIZE to HELD, always after one cycle),
*grow* (HELD to HELD, when a further trigger ORs the select mask into the target)
and *release* (HELD to RUN, when clear commands have emptied the target mask).

Top module: `dbg_halt_coord`

## Requirements
- R1: After reset the select mask, cause enables, counter-halt mask, halt requests, readback and counter are all zero, and the counter-run output is 1.
- R2: Command 0x32 loads the select mask from data bits [NCORES-1:0] and returns zero on readback. Command 0x31 returns the select mask, zero-extended, on readback in the cycle after the command.
- R3: Command 0x33 loads the cause enables from param[3:0] and the select mask from data. Command 0x34 returns the enables. Cause bit 0 is the halt-flag write, bit 1 the actionpoint, bit 2 the breakpoint and bit 3 the self-halt. Core i drives its causes on halt_cause[4i+3:4i] in the same bit order.
- R4: When a selected core has an enabled cause high at a clock edge, halt_req equals the select mask from that edge on, which is within one cycle.
- R5: A cause that is not enabled, or a cause raised by a core that is not selected, produces no halt request.
- R6: Once asserted, a halt-request bit stays set until a clear command (0x35) names it in its data mask. A clear that arrives in the first cycle of a halt is ignored. The request stays set after the causes drop.
- R7: Command 0x42 replaces the counter-halt mask with the data word and command 0x41 returns it. A read-modify-write that adds one core keeps the other bits of the mask.
- R8: The counter grows by exactly 1 per cycle while counter-run is 1. Counter-run is 0 and the counter holds while any core in the counter-halt mask has its halt request or any cause line high.
- R9: Command 0x43 returns counter bits [31:0] and captures bits [63:32] in the same cycle. Command 0x44 returns the captured high word.
- R10: A command code that is not listed in R2 to R11 changes no state and returns zero on readback.
- R11: Command 0x36 returns the current halt-request vector on readback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_code | input | 8 | Command code |
| cmd_param | input | PW | Command parameter (cause enables for 0x33) |
| cmd_data | input | DW | Command data word (core masks) |
| halt_cause | input | 4*NCORES | Per-core halt-cause lines, four per core |
| rdback | output | DW | Readback register |
| halt_req | output | NCORES | Per-core halt requests |
| cnt_run | output | 1 | High while the shared counter advances |

## Verification
The assertions assume that every command lasts exactly one cycle with `cmd_valid` high. They also assume that halt-cause lines change only between clock edges, so a trigger or a freeze is decided on stable inputs. The stimulus changes inputs on the falling edge only and issues commands back to back with `cmd_valid` held for a single cycle. It drops a cause before releasing the cores, because a cause still high would re-trigger the halt through the grow transition. The counter is never run long enough for its high word to wrap, which keeps the expected high word at zero.

// File: rtl/hc_pkg.sv
`timescale 1ns/1ps
package hc_pkg;
    localparam int NCAUSE = 4;

    localparam logic [7:0] OP_RD_SEL    = 8'h31;
    localparam logic [7:0] OP_SET_SEL   = 8'h32;
    localparam logic [7:0] OP_SET_CAUSE = 8'h33;
    localparam logic [7:0] OP_RD_CAUSE  = 8'h34;
    localparam logic [7:0] OP_CLR_HALT  = 8'h35;
    localparam logic [7:0] OP_RD_HALT   = 8'h36;
    localparam logic [7:0] OP_RD_CORE   = 8'h41;
    localparam logic [7:0] OP_SET_CORE  = 8'h42;
    localparam logic [7:0] OP_RD_CNT_LO = 8'h43;
    localparam logic [7:0] OP_RD_CNT_HI = 8'h44;

    typedef enum logic [1:0] {
        S_RUN   = 2'd0,
        S_SEIZE = 2'd1,
        S_HELD  = 2'd2
    } hstate_e;
endpackage

// File: rtl/hc_cmd_regs.sv
`timescale 1ns/1ps
module hc_cmd_regs
    import hc_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int DW     = 32,
    parameter int PW     = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_valid,
    input  logic [7:0]           cmd_code,
    input  logic [PW-1:0]        cmd_param,
    input  logic [DW-1:0]        cmd_data,
    input  logic [NCORES-1:0]    halt_req,
    input  logic [DW-1:0]        cnt_lo,
    input  logic [DW-1:0]        cnt_hi_snap,
    output logic [NCORES-1:0]    sel_mask,
    output logic [NCAUSE-1:0]    cause_en,
    output logic [NCORES-1:0]    core_mask,
    output logic                 clr_valid,
    output logic [NCORES-1:0]    clr_mask,
    output logic                 snap_lo,
    output logic [DW-1:0]        rdback
);
    logic [NCORES-1:0] sel_q, core_q;
    logic [NCAUSE-1:0] en_q;
    logic [DW-1:0]     rd_q, rd_val;
    logic              known;
    logic              unused_bits;

    assign unused_bits = ^{cmd_param[PW-1:NCAUSE], cmd_data[DW-1:NCORES]};

    always_comb begin
        rd_val = '0;
        known  = 1'b1;
        case (cmd_code)
            OP_RD_SEL:    rd_val = DW'(sel_q);
            OP_RD_CAUSE:  rd_val = DW'(en_q);
            OP_RD_HALT:   rd_val = DW'(halt_req);
            OP_RD_CORE:   rd_val = DW'(core_q);
            OP_RD_CNT_LO: rd_val = cnt_lo;
            OP_RD_CNT_HI: rd_val = cnt_hi_snap;
            OP_SET_SEL, OP_SET_CAUSE, OP_CLR_HALT, OP_SET_CORE: rd_val = '0;
            default:      known = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q  <= '0;
            en_q   <= '0;
            core_q <= '0;
            rd_q   <= '0;
        end else if (cmd_valid) begin
            rd_q <= rd_val;
            case (cmd_code)
                OP_SET_SEL: sel_q <= cmd_data[NCORES-1:0];
                OP_SET_CAUSE: begin
                    en_q  <= cmd_param[NCAUSE-1:0];
                    sel_q <= cmd_data[NCORES-1:0];
                end
                OP_SET_CORE: core_q <= cmd_data[NCORES-1:0];
                default: ;
            endcase
        end
    end

    assign sel_mask  = sel_q;
    assign cause_en  = en_q;
    assign core_mask = core_q;
    assign rdback    = rd_q;
    assign clr_valid = cmd_valid && (cmd_code == OP_CLR_HALT);
    assign clr_mask  = cmd_data[NCORES-1:0];
    assign snap_lo   = cmd_valid && (cmd_code == OP_RD_CNT_LO);

    p_unknown_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !known) |=> ($stable(sel_q) && $stable(en_q) &&
                                   $stable(core_q) && rd_q == '0));

    p_core_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == OP_SET_CORE) |=> core_q == $past(cmd_data[NCORES-1:0]));

    p_cause_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_code == OP_SET_CAUSE) |=> en_q == $past(cmd_param[NCAUSE-1:0]));
endmodule

// File: rtl/hc_halt_fsm.sv
`timescale 1ns/1ps
module hc_halt_fsm
    import hc_pkg::*;
#(
    parameter int NCORES = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCORES-1:0]        sel_mask,
    input  logic [NCAUSE-1:0]        cause_en,
    input  logic [NCORES*NCAUSE-1:0] halt_cause,
    input  logic                     clr_valid,
    input  logic [NCORES-1:0]        clr_mask,
    output logic [NCORES-1:0]        halt_req
);
    hstate_e           st, nxt;
    logic [NCORES-1:0] tgt, tgt_n, core_hit, clr, grow;
    logic              trig;

    for (genvar i = 0; i < NCORES; i++) begin : g_hit
        assign core_hit[i] = |(halt_cause[NCAUSE*i +: NCAUSE] & cause_en);
    end

    assign trig = |(core_hit & sel_mask);

    always_comb begin
        clr   = clr_valid ? clr_mask : '0;
        grow  = trig ? sel_mask : '0;
        nxt   = st;
        tgt_n = tgt;
        unique case (st)
            S_RUN: begin
                if (trig) begin
                    nxt   = S_SEIZE;
                    tgt_n = sel_mask;
                end
            end
            S_SEIZE: begin
                nxt   = S_HELD;
                tgt_n = tgt | grow;
            end
            S_HELD: begin
                tgt_n = (tgt & ~clr) | grow;
                if (tgt_n == '0) nxt = S_RUN;
            end
            default: begin
                nxt   = S_RUN;
                tgt_n = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st <= S_RUN;
        else        st <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tgt <= '0;
        else        tgt <= tgt_n;
    end

    assign halt_req = tgt;

    p_trigger_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN && trig) |=> halt_req == $past(sel_mask));

    p_no_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (st == S_RUN && !trig) |=> st == S_RUN);

    p_run_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_RUN |-> halt_req == '0);

    p_seize_settles_r6: assert property (@(posedge clk) disable iff (!rst_n)
        st == S_SEIZE |=> st == S_HELD);

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st != S_RUN && !clr_valid && !trig) |=> $stable(halt_req));
endmodule

// File: rtl/hc_gcounter.sv
`timescale 1ns/1ps
module hc_gcounter
    import hc_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int DW     = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NCORES-1:0]        core_mask,
    input  logic [NCORES-1:0]        halt_req,
    input  logic [NCORES*NCAUSE-1:0] halt_cause,
    input  logic                     snap_lo,
    output logic                     run,
    output logic [DW-1:0]            cnt_lo,
    output logic [DW-1:0]            cnt_hi_snap
);
    localparam int CNT_W = 2 * DW;

    logic [CNT_W-1:0]  cnt_q;
    logic [DW-1:0]     hi_q;
    logic [NCORES-1:0] halted;

    for (genvar i = 0; i < NCORES; i++) begin : g_halted
        assign halted[i] = halt_req[i] | (|halt_cause[NCAUSE*i +: NCAUSE]);
    end

    assign run = ~|(core_mask & halted);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            hi_q  <= '0;
        end else begin
            if (run)     cnt_q <= cnt_q + CNT_W'(1);
            if (snap_lo) hi_q  <= cnt_q[CNT_W-1:DW];
        end
    end

    assign cnt_lo      = cnt_q[DW-1:0];
    assign cnt_hi_snap = hi_q;

    p_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        run |=> cnt_q == $past(cnt_q) + CNT_W'(1));

    p_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> $stable(cnt_q));

    p_snap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        snap_lo |=> hi_q == $past(cnt_q[CNT_W-1:DW]));
endmodule

// File: rtl/dbg_halt_coord.sv
`timescale 1ns/1ps
module dbg_halt_coord
    import hc_pkg::*;
#(
    parameter int NCORES = 4,
    parameter int DW     = 32,
    parameter int PW     = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     cmd_valid,
    input  logic [7:0]               cmd_code,
    input  logic [PW-1:0]            cmd_param,
    input  logic [DW-1:0]            cmd_data,
    input  logic [NCORES*NCAUSE-1:0] halt_cause,
    output logic [DW-1:0]            rdback,
    output logic [NCORES-1:0]        halt_req,
    output logic                     cnt_run
);
    logic [NCORES-1:0] sel_mask, core_mask, clr_mask;
    logic [NCAUSE-1:0] cause_en;
    logic              clr_valid, snap_lo;
    logic [DW-1:0]     cnt_lo, cnt_hi_snap;

    hc_cmd_regs #(.NCORES(NCORES), .DW(DW), .PW(PW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_param(cmd_param), .cmd_data(cmd_data),
        .halt_req(halt_req), .cnt_lo(cnt_lo), .cnt_hi_snap(cnt_hi_snap),
        .sel_mask(sel_mask), .cause_en(cause_en), .core_mask(core_mask),
        .clr_valid(clr_valid), .clr_mask(clr_mask), .snap_lo(snap_lo),
        .rdback(rdback)
    );

    hc_halt_fsm #(.NCORES(NCORES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .sel_mask(sel_mask), .cause_en(cause_en), .halt_cause(halt_cause),
        .clr_valid(clr_valid), .clr_mask(clr_mask),
        .halt_req(halt_req)
    );

    hc_gcounter #(.NCORES(NCORES), .DW(DW)) u_cnt (
        .clk(clk), .rst_n(rst_n),
        .core_mask(core_mask), .halt_req(halt_req), .halt_cause(halt_cause),
        .snap_lo(snap_lo),
        .run(cnt_run), .cnt_lo(cnt_lo), .cnt_hi_snap(cnt_hi_snap)
    );
endmodule

// File: tb/test_dbg_halt_coord.sv
`timescale 1ns/1ps
module test_dbg_halt_coord;
    localparam int NC = 4;
    localparam int DW = 32;
    localparam int PW = 16;

    localparam logic [7:0] C_RD_SEL = 8'h31, C_SET_SEL = 8'h32, C_SET_CAUSE = 8'h33,
                           C_RD_CAUSE = 8'h34, C_CLR = 8'h35, C_RD_HALT = 8'h36,
                           C_RD_CORE = 8'h41, C_SET_CORE = 8'h42,
                           C_RD_LO = 8'h43, C_RD_HI = 8'h44, C_BOGUS = 8'h7E;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic [7:0]      cmd_code = '0;
    logic [PW-1:0]   cmd_param = '0;
    logic [DW-1:0]   cmd_data = '0;
    logic [NC*4-1:0] halt_cause = '0;
    logic [DW-1:0]   rdback;
    logic [NC-1:0]   halt_req;
    logic            cnt_run;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        bit          chk;
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb_q[$];
    item_t mon_it;
    bit    pend = 1'b0;

    dbg_halt_coord #(.NCORES(NC), .DW(DW), .PW(PW)) i_dbg_halt_coord (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_param(cmd_param), .cmd_data(cmd_data), .halt_cause(halt_cause),
        .rdback(rdback), .halt_req(halt_req), .cnt_run(cnt_run)
    );

    always #2 clk = ~clk;

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    // Driver: called at a falling edge; pushes the expected readback.
    task automatic cmd(input logic [7:0] c, input logic [15:0] p, input logic [31:0] d,
                       input bit chk, input logic [31:0] exp, input string tag,
                       output logic [31:0] got);
        item_t it;
        it.chk = chk;
        it.exp = exp;
        it.tag = tag;
        sb_q.push_back(it);
        cmd_valid = 1'b1;
        cmd_code  = c;
        cmd_param = p;
        cmd_data  = d;
        @(negedge clk);
        cmd_valid = 1'b0;
        got = rdback;
    endtask

    // Monitor: compares readback one cycle after each accepted command.
    always @(posedge clk) pend <= cmd_valid;
    always @(negedge clk) begin
        if (pend && sb_q.size() > 0) begin
            mon_it = sb_q.pop_front();
            if (mon_it.chk) check(mon_it.tag, rdback, mon_it.exp);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        logic [31:0] g, a, b;
        repeat (3) @(negedge clk);
        check("R1 halt_req in reset", 32'(halt_req), 32'h0);
        check("R1 cnt_run in reset", 32'(cnt_run), 32'h1);
        check("R1 rdback in reset", rdback, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        cmd(C_RD_SEL, 16'h0, 32'h0, 1, 32'h0, "R1 select after reset", g);
        cmd(C_RD_CORE, 16'h0, 32'h0, 1, 32'h0, "R1 core mask after reset", g);
        cmd(C_RD_LO, 16'h0, 32'h0, 0, 32'h0, "", a);
        check("R1 counter starts near zero", 32'(a < 32'd16), 32'h1);

        // R2 select mask
        cmd(C_SET_SEL, 16'h0, 32'h5, 1, 32'h0, "R2 write returns zero", g);
        cmd(C_RD_SEL, 16'h0, 32'h0, 1, 32'h5, "R2 read select", g);
        cmd(C_SET_SEL, 16'h0, 32'hFFFF_FFF3, 1, 32'h0, "R2 write returns zero", g);
        cmd(C_RD_SEL, 16'h0, 32'h0, 1, 32'h3, "R2 read select truncated", g);

        // R3 cause enables
        cmd(C_SET_CAUSE, 16'h000F, 32'h3, 1, 32'h0, "R3 set cause", g);
        cmd(C_RD_CAUSE, 16'h0, 32'h0, 1, 32'hF, "R3 read cause all", g);
        cmd(C_SET_CAUSE, 16'h0004, 32'h3, 1, 32'h0, "R3 set cause bkpt", g);
        cmd(C_RD_CAUSE, 16'h0, 32'h0, 1, 32'h4, "R3 read cause bkpt", g);
        cmd(C_RD_SEL, 16'h0, 32'h0, 1, 32'h3, "R3 select via cause cmd", g);

        // R5 no trigger: disabled cause on selected core, enabled cause on unselected core
        halt_cause = 16'h0002;
        repeat (3) @(negedge clk);
        check("R5 disabled cause", 32'(halt_req), 32'h0);
        halt_cause = 16'h0400;
        repeat (3) @(negedge clk);
        check("R5 unselected core", 32'(halt_req), 32'h0);
        halt_cause = 16'h0;
        @(negedge clk);

        // R4 trigger by core 1 breakpoint, R6 hold and clear
        halt_cause = 16'h0040;
        @(negedge clk);
        check("R4 halt to selected cores", 32'(halt_req), 32'h3);
        halt_cause = 16'h0;
        cmd(C_CLR, 16'h0, 32'hF, 1, 32'h0, "R6 clear returns zero", g);
        check("R6 clear in first cycle ignored", 32'(halt_req), 32'h3);
        repeat (3) @(negedge clk);
        check("R6 held after cause drops", 32'(halt_req), 32'h3);
        cmd(C_RD_HALT, 16'h0, 32'h0, 1, 32'h3, "R11 read halt status", g);
        cmd(C_CLR, 16'h0, 32'h1, 0, 32'h0, "", g);
        check("R6 partial clear", 32'(halt_req), 32'h2);
        cmd(C_CLR, 16'h0, 32'h2, 0, 32'h0, "", g);
        check("R6 full clear", 32'(halt_req), 32'h0);
        cmd(C_RD_HALT, 16'h0, 32'h0, 1, 32'h0, "R11 halt status cleared", g);

        // R7 counter-halt mask with read-modify-write
        cmd(C_SET_CORE, 16'h0, 32'h4, 1, 32'h0, "R7 set core", g);
        cmd(C_RD_CORE, 16'h0, 32'h0, 1, 32'h4, "R7 read core", g);
        cmd(C_RD_CORE, 16'h0, 32'h0, 0, 32'h0, "", a);
        cmd(C_SET_CORE, 16'h0, a | 32'h1, 1, 32'h0, "R7 rmw write", g);
        cmd(C_RD_CORE, 16'h0, 32'h0, 1, 32'h5, "R7 rmw keeps other bits", g);

        // R8 counting and freezing
        check("R8 run with no halted core", 32'(cnt_run), 32'h1);
        cmd(C_RD_LO, 16'h0, 32'h0, 0, 32'h0, "", a);
        repeat (4) @(negedge clk);
        cmd(C_RD_LO, 16'h0, 32'h0, 0, 32'h0, "", b);
        check("R8 counts one per cycle", b - a, 32'd5);
        halt_cause = 16'h0800;
        #1;
        check("R8 cause freezes counter", 32'(cnt_run), 32'h0);
        check("R5 unselected cause no request", 32'(halt_req), 32'h0);
        @(negedge clk);
        cmd(C_RD_LO, 16'h0, 32'h0, 0, 32'h0, "", a);
        repeat (4) @(negedge clk);
        cmd(C_RD_LO, 16'h0, 32'h0, 0, 32'h0, "", b);
        check("R8 frozen counter holds", b - a, 32'd0);
        halt_cause = 16'h0;
        #1;
        check("R8 run resumes", 32'(cnt_run), 32'h1);
        @(negedge clk);
        halt_cause = 16'h0004;
        @(negedge clk);
        check("R4 core0 breakpoint halts", 32'(halt_req), 32'h3);
        halt_cause = 16'h0;
        #1;
        check("R8 halt request freezes counter", 32'(cnt_run), 32'h0);
        @(negedge clk);
        cmd(C_CLR, 16'h0, 32'h3, 0, 32'h0, "", g);
        check("R6 released", 32'(halt_req), 32'h0);
        check("R8 run after release", 32'(cnt_run), 32'h1);

        // R9 split counter read
        cmd(C_RD_LO, 16'h0, 32'h0, 0, 32'h0, "", a);
        check("R9 low word advanced", 32'(a > 32'd20), 32'h1);
        cmd(C_RD_HI, 16'h0, 32'h0, 1, 32'h0, "R9 high word snapshot", g);

        // R10 unknown code
        cmd(C_BOGUS, 16'hFFFF, 32'hFFFF_FFFF, 1, 32'h0, "R10 unknown returns zero", g);
        cmd(C_RD_SEL, 16'h0, 32'h0, 1, 32'h3, "R10 select unchanged", g);
        cmd(C_RD_CORE, 16'h0, 32'h0, 1, 32'h5, "R10 core mask unchanged", g);
        cmd(C_RD_CAUSE, 16'h0, 32'h0, 1, 32'h4, "R10 enables unchanged", g);
        cmd(C_BOGUS, 16'h0, 32'h0, 1, 32'h0, "R10 unknown after read", g);
        check("R10 no halt", 32'(halt_req), 32'h0);

        repeat (2) @(negedge clk);
        summary();
        $finish;
    end
endmodule